// File: doc/BRIEF.md
# IO Coherency Window Decoder

This block sits on the request channel that carries IO and DMA transactions towards memory. For each request it decides whether the address lies in one programmable window of memory that must be kept coherent with processor caches. A request that hits the window is flagged for the coherent path, and any other request is flagged for the plain path. The verdict is registered and appears one clock after the request.

Software programs four settings through a simple write port: a size code, a base page, a partial-coherency bit and a global enable. The size is a log2 exponent. Code S gives a window of 2^(S+12) bytes, so 0x11 selects 512 MB and 0x12 selects 1 GB. The base is held in 4 KB pages. A window is always a power of two of at least 4 KB, and it is naturally aligned. Any base bits that fall below the window size are ignored rather than shifting the window. Nothing is flagged coherent while the enable is clear.

Top module: `coh_window_decoder`

## Requirements
- R1: After reset all four settings are zero, and `rsp_valid`, `rsp_coherent` and `rsp_partial` are low.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: With size code S, a window of 2^(S+12) bytes applies. A request is coherent when address bits at and above position S+12 equal the same bits of the base address, with the enable set.
- R4: The base register takes write data bits [ADDR_W-13:0] as the page number, so the base address is that value shifted left by 12. Higher write data bits are discarded.
- R5: Base bits below position S+12 are ignored, so a misaligned base selects the aligned window that contains it.
- R6: When S+12 is at least ADDR_W, every address is inside the window.
- R7: While the enable bit is 0, `rsp_coherent` and `rsp_partial` stay low for every request.
- R8: `rsp_partial` is high exactly when `rsp_coherent` is high and the partial bit is 1.
- R9: A settings write in the same cycle as a request does not affect that request. The request after the write uses the new value.
- R10: `cfg_sel` chooses the register: 0 for size (data bits [4:0]), 1 for base page, 2 for partial (bit 0) and 3 for enable (bit 0). Other data bits are dropped.
- R11: `rsp_coherent` is low in any cycle where `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 2 | Settings register select |
| cfg_wdata | input | 32 | Settings write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| rsp_valid | output | 1 | Verdict present (one cycle after request) |
| rsp_coherent | output | 1 | Request hit the coherent window |
| rsp_partial | output | 1 | Hit with partial coherency selected |

## Verification
A settings write and a request can reach the block in the same cycle. The request must then be judged under the settings that held before the write. The bench provokes this by driving a size, base or enable write together with a request whose verdict differs between the old and new values. It expects the old verdict first, and then the new verdict for the very next request. The bulk of the run sweeps every size code, including the saturated ones, against every base page and a grid of addresses. The expected hit is computed by shifting both the address and the base.

// File: rtl/coh_ap_pkg.sv
package coh_ap_pkg;
   localparam int PAGE_SHIFT = 12;
   localparam int SIZE_W     = 5;
   localparam int LG_W       = 7;

   typedef enum logic [1:0] {
      SEL_SIZE = 2'd0,
      SEL_BASE = 2'd1,
      SEL_PART = 2'd2,
      SEL_EN   = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/coh_ap_cfg.sv
module coh_ap_cfg
   import coh_ap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [1:0]                   sel,
   input  logic [31:0]                  wdata,
   output logic [SIZE_W-1:0]            size_code,
   output logic [ADDR_W-PAGE_SHIFT-1:0] base_pg,
   output logic                         partial,
   output logic                         enable
);
   localparam int PG_W = ADDR_W - PAGE_SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_code <= '0;
         base_pg   <= '0;
         partial   <= 1'b0;
         enable    <= 1'b0;
      end else if (we) begin
         unique case (cfg_sel_e'(sel))
            SEL_SIZE: size_code <= wdata[SIZE_W-1:0];
            SEL_BASE: base_pg   <= wdata[PG_W-1:0];
            SEL_PART: partial   <= wdata[0];
            SEL_EN:   enable    <= wdata[0];
         endcase
      end
   end
endmodule

// File: rtl/coh_ap_mask.sv
module coh_ap_mask
   import coh_ap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [SIZE_W-1:0] size_code,
   output logic [ADDR_W-1:0] hi_mask
);
   logic [LG_W-1:0] lg;
   assign lg = LG_W'(size_code) + LG_W'(PAGE_SHIFT);

   for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
      if (g < PAGE_SHIFT) begin : g_low
         assign hi_mask[g] = 1'b0;
      end else begin : g_cmp
         assign hi_mask[g] = (LG_W'(g) >= lg);
      end
   end
endmodule

// File: rtl/coh_ap_match.sv
module coh_ap_match
   import coh_ap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [ADDR_W-PAGE_SHIFT-1:0] base_pg,
   input  logic [ADDR_W-1:0]            hi_mask,
   input  logic                         enable,
   input  logic                         partial,
   output logic                         rsp_valid,
   output logic                         rsp_coherent,
   output logic                         rsp_partial
);
   logic [ADDR_W-1:0] base_addr;
   logic              hit;

   assign base_addr = {base_pg, {PAGE_SHIFT{1'b0}}};
   assign hit       = (((req_addr ^ base_addr) & hi_mask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_coherent <= 1'b0;
         rsp_partial  <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_coherent <= req_valid & enable & hit;
         rsp_partial  <= req_valid & enable & hit & partial;
      end
   end
endmodule

// File: rtl/coh_window_decoder.sv
module coh_window_decoder
   import coh_ap_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_coherent,
   output logic              rsp_partial
);
   localparam int PG_W = ADDR_W - PAGE_SHIFT;

   if (ADDR_W < PAGE_SHIFT + 1 || PG_W > 32) begin : g_bad_width
      $error("coh_window_decoder: ADDR_W out of range");
   end

   logic [SIZE_W-1:0] size_code;
   logic [PG_W-1:0]   base_pg;
   logic              cfg_partial;
   logic              cfg_enable;
   logic [ADDR_W-1:0] hi_mask;

   coh_ap_cfg #(.ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .size_code(size_code), .base_pg(base_pg),
      .partial(cfg_partial), .enable(cfg_enable)
   );

   coh_ap_mask #(.ADDR_W(ADDR_W)) u_mask (
      .size_code(size_code), .hi_mask(hi_mask)
   );

   coh_ap_match #(.ADDR_W(ADDR_W)) u_match (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .base_pg(base_pg), .hi_mask(hi_mask), .enable(cfg_enable),
      .partial(cfg_partial), .rsp_valid(rsp_valid),
      .rsp_coherent(rsp_coherent), .rsp_partial(rsp_partial)
   );
endmodule

// File: rtl/coh_window_checker.sv
module coh_window_checker (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic enable,
   input logic rsp_valid,
   input logic rsp_coherent,
   input logic rsp_partial
);
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r11_coh_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_coherent |-> rsp_valid);
   a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !enable) |=> (!rsp_coherent && !rsp_partial));
   a_r8_partial_needs_coh: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_partial |-> rsp_coherent);
endmodule

bind coh_window_decoder coh_window_checker u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .enable(cfg_enable),
   .rsp_valid(rsp_valid), .rsp_coherent(rsp_coherent), .rsp_partial(rsp_partial)
);

// File: tb/sim_coh_window_decoder.sv
`timescale 1ns/1ps
module sim_coh_window_decoder;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_coherent, rsp_partial;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   coh_window_decoder #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_coherent(rsp_coherent), .rsp_partial(rsp_partial)
   );

   task automatic chk(input string tag, input logic got, input logic exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic req(input logic [AW-1:0] a, input logic ec, input logic ep, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      chk(tag, rsp_valid, 1'b1);
      chk(tag, rsp_coherent, ec);
      chk(tag, rsp_partial, ep);
   endtask

   function automatic logic model(input int s, input int b, input int a);
      int lg;
      lg = s + 12;
      if (lg >= AW) return 1'b1;
      return ((a >> lg) == ((b << 12) >> lg));
   endfunction

   initial begin
      #(200000 * 5.0);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rsp_valid", rsp_valid, 1'b0);
      chk("R1 rsp_coherent", rsp_coherent, 1'b0);
      rst_n = 1'b1;
      // R1/R7: default enable=0, base 0, size 0 -> address 0 not coherent
      req(16'h0000, 1'b0, 1'b0, "R1 R7 default disabled");
      // R11: idle cycle
      @(negedge clk);
      chk("R11 idle valid", rsp_valid, 1'b0);
      chk("R11 idle coherent", rsp_coherent, 1'b0);

      // R10/R4: junk above field widths is dropped
      wr(2'd3, 32'hFFFF_FFF1);          // enable = 1
      wr(2'd0, 32'h0000_00E1);          // size code 1 (8 KB)
      wr(2'd1, 32'hFFFF_FFF4);          // base page 4 -> 0x4000
      wr(2'd2, 32'h0000_0002);          // partial = 0
      req(16'h5FFF, 1'b1, 1'b0, "R10 R4 in window");
      req(16'h6000, 1'b0, 1'b0, "R10 R4 above window");
      req(16'h3FFF, 1'b0, 1'b0, "R4 below window");

      // R9: write coincident with request
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0;   // disable
      req_valid = 1'b1; req_addr = 16'h4000;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk("R9 old enable used", rsp_coherent, 1'b1);
      req(16'h4000, 1'b0, 1'b0, "R9 new enable used");
      wr(2'd3, 32'h1);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h8;    // base 0x8000
      req_valid = 1'b1; req_addr = 16'h8000;
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      chk("R9 old base used", rsp_coherent, 1'b0);
      req(16'h8000, 1'b1, 1'b0, "R9 new base used");

      // R7: full sweep with enable off
      wr(2'd3, 32'h0);
      wr(2'd0, 32'd4);
      for (int a = 0; a < 256; a += 17) req(AW'(a << 8), 1'b0, 1'b0, "R7 disabled sweep");
      wr(2'd3, 32'h1);

      // R3/R5/R6/R8: sweep sizes, bases, addresses
      for (int s = 0; s < 6; s++) begin
         for (int b = 0; b < 16; b++) begin
            bit p;
            string tag;
            p = (b % 3 == 0);
            wr(2'd0, 32'(s));
            wr(2'd1, 32'(b));
            wr(2'd2, {31'b0, p});
            if (s + 12 >= AW) tag = "R6 saturated size";
            else if ((b & ((1 << s) - 1)) != 0) tag = "R5 misaligned base";
            else tag = "R3 R8 aligned window";
            for (int a = 0; a < 256; a++) begin
               logic e;
               e = model(s, b, a << 8);
               req(AW'(a << 8), e, e & p, tag);
            end
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule